// File: doc/BRIEF.md
# Four-Core Thread Swap Decision Agent

This block decides, once per fixed migration interval, whether two of the four cores in a cluster should exchange their threads. Each core supplies two figures: a predicted emergency level (how often its timing is expected to be violated) and an estimate of its slow-varying delay (the mean delay, which tracks process and temperature). When the interval expires, the agent captures all eight figures. It picks the core with the highest emergency level as the source and the core with the smallest slow delay as the destination. It then issues a single-cycle migrate command naming both cores. The command means an exchange: the two threads swap places.

The agent is a three-state machine. ST_IDLE waits for the interval counter to expire and captures the inputs on the expiry edge (transition IDLE->RANK). ST_RANK registers the results of two ranking comparators (transition RANK->ISSUE, unconditional). ST_ISSUE presents the command for one cycle when it is allowed (transition ISSUE->IDLE, unconditional). A command is suppressed when source and destination are the same core, or when no core has a nonzero emergency level.

Top module: `thread_swap_agent`

## Requirements
- R1: The inputs are captured only on the clock edge at which the interval counter expires. The first capture is the INTERVAL-th rising edge after reset is released, and each later capture follows INTERVAL edges after the previous one. Input values at any other edge have no effect on the command.
- R2: The source is the core with the largest captured emergency level. When several cores share that largest level, the lowest core index wins. Core i's level occupies bits [i*EL_W +: EL_W] of `core_el`.
- R3: The destination is the core with the smallest captured slow delay. When several cores share that smallest delay, the lowest core index wins. Core i's delay occupies bits [i*DLY_W +: DLY_W] of `core_dly`.
- R4: No command is issued when the source and the destination are the same core.
- R5: No command is issued when every captured emergency level is zero.
- R6: A command is a one-cycle high pulse on `mig_valid`. It is high during the second cycle after the capture edge, with the source and destination as binary core indices on `mig_src` and `mig_dst`. Both index outputs read zero whenever `mig_valid` is low.
- R7: While reset is asserted and right after it is released, `mig_valid`, `mig_src` and `mig_dst` are zero. A reset in mid-interval restarts the interval count from zero.
- R8: At most one command is issued per interval, and no pulse appears outside the issue cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_el | input | NUM_CORES*EL_W | Predicted emergency level per core, core i at [i*EL_W +: EL_W] |
| core_dly | input | NUM_CORES*DLY_W | Slow delay estimate per core, core i at [i*DLY_W +: DLY_W] |
| mig_valid | output | 1 | One-cycle migrate (swap) command |
| mig_src | output | IDX_W | Core with the highest emergency level |
| mig_dst | output | IDX_W | Core with the smallest slow delay |

## Verification
The decision is tried with several input patterns:
- Distinct values with unique extremes show that the emergency and delay comparisons are independent.
- Equal maxima and equal minima (including all delays equal) separate lowest-index tie breaking from highest-index tie breaking.
- A pattern where one core is both the worst and the slowest-free core, and an all-zero emergency pattern, show suppression apart from normal issue.
- Full-scale values expose truncated comparisons.

Between captures the inputs are replaced with values that would give a different answer; this shows that only the expiry edge samples. A reset just before expiry shows that the interval count restarts.

// File: rtl/tm_agent_pkg.sv
package tm_agent_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RANK  = 2'd1,
        ST_ISSUE = 2'd2
    } tm_state_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tm_interval_timer.sv
module tm_interval_timer #(
    parameter int INTERVAL = 400000
) (
    input  logic clk,
    input  logic rst_n,
    output logic expire
);
    localparam int CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = (cnt == LAST);

    // R1
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R1
    cnt_wraps_after_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt == '0));

endmodule

// File: rtl/tm_rank_select.sv
module tm_rank_select #(
    parameter int NUM   = 4,
    parameter int VAL_W = 16,
    parameter bit PICK_MAX = 1'b1,
    localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM*VAL_W-1:0] vals,
    output logic [IDX_W-1:0]     win_idx
);
    logic [VAL_W-1:0] best;

    // Linear scan with strict comparison: an equal value later in the scan
    // never displaces an earlier one, so ties resolve to the lowest index.
    generate
        if (PICK_MAX) begin : g_max
            always_comb begin
                best    = vals[VAL_W-1:0];
                win_idx = '0;
                for (int j = 1; j < NUM; j++) begin
                    if (vals[j*VAL_W +: VAL_W] > best) begin
                        best    = vals[j*VAL_W +: VAL_W];
                        win_idx = IDX_W'(j);
                    end
                end
            end
        end else begin : g_min
            always_comb begin
                best    = vals[VAL_W-1:0];
                win_idx = '0;
                for (int j = 1; j < NUM; j++) begin
                    if (vals[j*VAL_W +: VAL_W] < best) begin
                        best    = vals[j*VAL_W +: VAL_W];
                        win_idx = IDX_W'(j);
                    end
                end
            end
        end
    endgenerate

    genvar k;
    generate
        for (k = 0; k < NUM; k++) begin : g_order
            if (PICK_MAX) begin : g_chk_max
                // R2
                rank_max_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    vals[k*VAL_W +: VAL_W] <= vals[win_idx*VAL_W +: VAL_W]);
                // R2
                rank_max_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (IDX_W'(k) < win_idx) |->
                    (vals[k*VAL_W +: VAL_W] < vals[win_idx*VAL_W +: VAL_W]));
            end else begin : g_chk_min
                // R3
                rank_min_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    vals[k*VAL_W +: VAL_W] >= vals[win_idx*VAL_W +: VAL_W]);
                // R3
                rank_min_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (IDX_W'(k) < win_idx) |->
                    (vals[k*VAL_W +: VAL_W] > vals[win_idx*VAL_W +: VAL_W]));
            end
        end
    endgenerate

endmodule

// File: rtl/tm_decide_fsm.sv
module tm_decide_fsm
    import tm_agent_pkg::*;
#(
    parameter int NUM   = 4,
    parameter int EL_W  = 16,
    parameter int DLY_W = 16,
    localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 expire,
    input  logic [NUM*EL_W-1:0]  el_in,
    input  logic [NUM*DLY_W-1:0] dly_in,
    input  logic [IDX_W-1:0]     src_idx,
    input  logic [IDX_W-1:0]     dst_idx,
    output logic [NUM*EL_W-1:0]  el_cap,
    output logic [NUM*DLY_W-1:0] dly_cap,
    output logic                 mig_valid,
    output logic [IDX_W-1:0]     mig_src,
    output logic [IDX_W-1:0]     mig_dst
);
    tm_state_e        state, nxt;
    logic [IDX_W-1:0] src_q, dst_q;
    logic             go_q;
    logic [EL_W-1:0]  src_el;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Transitions: IDLE->RANK on expiry, RANK->ISSUE, ISSUE->IDLE
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  nxt = expire ? ST_RANK : ST_IDLE;
            ST_RANK:  nxt = ST_ISSUE;
            ST_ISSUE: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    assign src_el = el_cap[src_idx*EL_W +: EL_W];

    // Capture and decision registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            el_cap  <= '0;
            dly_cap <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            go_q    <= 1'b0;
        end else begin
            if (state == ST_IDLE && expire) begin
                el_cap  <= el_in;
                dly_cap <= dly_in;
            end
            if (state == ST_RANK) begin
                src_q <= src_idx;
                dst_q <= dst_idx;
                go_q  <= (src_el != '0) && (src_idx != dst_idx);
            end
        end
    end

    // Outputs
    always_comb begin
        mig_valid = 1'b0;
        mig_src   = '0;
        mig_dst   = '0;
        unique case (state)
            ST_ISSUE: begin
                mig_valid = go_q;
                mig_src   = go_q ? src_q : '0;
                mig_dst   = go_q ? dst_q : '0;
            end
            ST_IDLE, ST_RANK: begin
                mig_valid = 1'b0;
            end
            default: begin
                mig_valid = 1'b0;
            end
        endcase
    end

    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mig_valid |=> !mig_valid);

    // R6
    issue_after_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mig_valid |-> ($past(state) == ST_RANK));

    // R4
    src_ne_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mig_valid |-> (mig_src != mig_dst));

    // R5
    src_level_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mig_valid |-> (el_cap[mig_src*EL_W +: EL_W] != '0));

    // R1
    expire_in_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> (state == ST_IDLE));

    // R6
    idx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mig_valid |-> (mig_src == '0 && mig_dst == '0));

endmodule

// File: rtl/thread_swap_agent.sv
module thread_swap_agent #(
    parameter int NUM_CORES = 4,
    parameter int EL_W      = 16,
    parameter int DLY_W     = 16,
    parameter int INTERVAL  = 400000,
    localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CORES*EL_W-1:0]  core_el,
    input  logic [NUM_CORES*DLY_W-1:0] core_dly,
    output logic                       mig_valid,
    output logic [IDX_W-1:0]           mig_src,
    output logic [IDX_W-1:0]           mig_dst
);
    logic                       expire;
    logic [NUM_CORES*EL_W-1:0]  el_cap;
    logic [NUM_CORES*DLY_W-1:0] dly_cap;
    logic [IDX_W-1:0]           src_idx, dst_idx;

    tm_interval_timer #(
        .INTERVAL (INTERVAL)
    ) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .expire (expire)
    );

    tm_rank_select #(
        .NUM      (NUM_CORES),
        .VAL_W    (EL_W),
        .PICK_MAX (1'b1)
    ) src_sel_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .vals    (el_cap),
        .win_idx (src_idx)
    );

    tm_rank_select #(
        .NUM      (NUM_CORES),
        .VAL_W    (DLY_W),
        .PICK_MAX (1'b0)
    ) dst_sel_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .vals    (dly_cap),
        .win_idx (dst_idx)
    );

    tm_decide_fsm #(
        .NUM   (NUM_CORES),
        .EL_W  (EL_W),
        .DLY_W (DLY_W)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire    (expire),
        .el_in     (core_el),
        .dly_in    (core_dly),
        .src_idx   (src_idx),
        .dst_idx   (dst_idx),
        .el_cap    (el_cap),
        .dly_cap   (dly_cap),
        .mig_valid (mig_valid),
        .mig_src   (mig_src),
        .mig_dst   (mig_dst)
    );

endmodule

// File: tb/thread_swap_agent_tb_top.sv
`timescale 1ns/1ps
module thread_swap_agent_tb_top;

    localparam int N    = 4;
    localparam int W    = 16;
    localparam int IVL  = 8;
    localparam int VW   = 133;
    localparam int NV   = 7;

    // Vector layout: {el3,el2,el1,el0, d3,d2,d1,d0, go, src[1:0], dst[1:0]}
    function automatic logic [VW-1:0] mk(
        input logic [W-1:0] e0, input logic [W-1:0] e1,
        input logic [W-1:0] e2, input logic [W-1:0] e3,
        input logic [W-1:0] d0, input logic [W-1:0] d1,
        input logic [W-1:0] d2, input logic [W-1:0] d3,
        input logic go, input logic [1:0] s, input logic [1:0] d);
        return {e3, e2, e1, e0, d3, d2, d1, d0, go, s, d};
    endfunction

    localparam logic [VW-1:0] VEC [0:NV-1] = '{
        mk(16'd5, 16'd9, 16'd2, 16'd1, 16'd100, 16'd80, 16'd60, 16'd90, 1'b1, 2'd1, 2'd2),
        mk(16'd7, 16'd3, 16'd7, 16'd0, 16'd50, 16'd40, 16'd40, 16'd60, 1'b1, 2'd0, 2'd1),
        mk(16'd1, 16'd2, 16'd3, 16'd9, 16'd9, 16'd9, 16'd9, 16'd5, 1'b0, 2'd0, 2'd0),
        mk(16'd0, 16'd0, 16'd0, 16'd0, 16'd10, 16'd5, 16'd7, 16'd8, 1'b0, 2'd0, 2'd0),
        mk(16'd0, 16'd0, 16'd0, 16'd1, 16'd1, 16'd2, 16'd3, 16'd4, 1'b1, 2'd3, 2'd0),
        mk(16'd3, 16'd8, 16'hFFFF, 16'hFFFF, 16'd9, 16'd0, 16'd4, 16'd0, 1'b1, 2'd2, 2'd1),
        mk(16'd0, 16'd0, 16'd4, 16'd0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b1, 2'd2, 2'd0)
    };

    localparam string VTAG [0:NV-1] = '{
        "R2 R3 distinct", "R2 R3 ties", "R4 same core", "R5 zero levels",
        "R2 R3 ends", "R2 R3 full scale", "R3 all equal"
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N*W-1:0] core_el = '0;
    logic [N*W-1:0] core_dly = '0;
    logic           mig_valid;
    logic [1:0]     mig_src, mig_dst;

    int checks = 0;
    int failures = 0;
    int pulses = 0;
    int exp_pulses = 0;

    always #10 clk = ~clk;

    thread_swap_agent #(
        .NUM_CORES (N),
        .EL_W      (W),
        .DLY_W     (W),
        .INTERVAL  (IVL)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .core_el   (core_el),
        .core_dly  (core_dly),
        .mig_valid (mig_valid),
        .mig_src   (mig_src),
        .mig_dst   (mig_dst)
    );

    always @(negedge clk) begin
        if (rst_n && mig_valid) pulses++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Precondition: at a negedge with IVL-1 rising edges left before the next capture.
    task automatic run_vec(input logic [VW-1:0] v, input string tag);
        logic       go;
        logic [1:0] es, ed;
        go = v[4];
        es = v[3:2];
        ed = v[1:0];
        core_el  = v[132:69];
        core_dly = v[68:5];
        @(posedge clk);
        @(negedge clk);
        chk(mig_valid == 1'b0, "R6", {tag, " pulse width"}, int'(mig_valid), 0);
        repeat (IVL - 2) @(posedge clk);
        @(negedge clk);
        // R1: values driven after the capture edge must not matter
        core_el  = {16'd0, 16'd0, 16'd0, 16'd0};
        core_dly = {16'd1, 16'd2, 16'd3, 16'd4};
        @(posedge clk);
        @(negedge clk);
        chk(mig_valid == go, "R6", {tag, " valid"}, int'(mig_valid), int'(go));
        chk(mig_src == (go ? es : 2'd0), "R2", {tag, " src"}, int'(mig_src),
            int'(go ? es : 2'd0));
        chk(mig_dst == (go ? ed : 2'd0), "R3", {tag, " dst"}, int'(mig_dst),
            int'(go ? ed : 2'd0));
        if (go) exp_pulses++;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7 reset state
        chk(mig_valid == 1'b0, "R7", "valid in reset", int'(mig_valid), 0);
        chk(mig_src == 2'd0 && mig_dst == 2'd0, "R7", "indices in reset",
            int'({mig_src, mig_dst}), 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(mig_valid == 1'b0, "R7", "valid after release", int'(mig_valid), 0);

        for (int i = 0; i < NV; i++) begin
            run_vec(VEC[i], VTAG[i]);
        end

        // R7: reset one edge before expiry restarts the interval
        core_el  = VEC[0][132:69];
        core_dly = VEC[0][68:5];
        repeat (IVL - 2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(mig_valid == 1'b0, "R7", "no command through reset", int'(mig_valid), 0);
        rst_n = 1'b1;
        // R1: capture is IVL edges after release; one edge gone already
        @(posedge clk);
        @(negedge clk);
        run_vec(VEC[4], "R1 R7 restart");

        // R8: pulses total equal the issue cycles expected
        @(posedge clk);
        @(negedge clk);
        chk(pulses == exp_pulses, "R8", "pulse count", pulses, exp_pulses);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule